// File: doc/BRIEF.md
# Data-Bus Region Decoder with System Registers and Byte Port

This block sits on a processor's data bus and splits the address space into three regions. The lowest four words form a bank of read-only system registers. Two of them return fixed constants and the other two return the live program counter and status word. A small I/O window holds a status-polled byte peripheral, which exchanges whole bytes with the outside through ready/valid handshakes in both directions. Every address at or above a RAM boundary (512 MB by default) is passed to an external RAM port.

A read or a write is presented for one cycle with its strobe. The block returns an acknowledge, and for reads the data, on the following cycle. For RAM reads, that data comes from the external RAM, which must answer with a fixed one-cycle latency. Any other I/O address is unmapped: it reads as zero and takes no action on a write. This covers the reserved per-processor windows in the lowest 128 MB, apart from the system registers.

Top module: `dbus_io_decoder`

## Requirements
- R1: An access at an address >= 0x2000_0000 drives ram_rd or ram_wr in the same cycle, with ram_addr equal to cpu_addr and ram_wdata equal to cpu_wdata. An access below that address never asserts ram_rd or ram_wr.
- R2: A read of address 0x0 returns 0x0000_0000, and a read of address 0x4 returns 0x8000_0000.
- R3: A read of 0x8 returns the value that sys_pc had in the access cycle. A read of 0xC returns the value that sys_psw had in that cycle.
- R4: A write to any of addresses 0x0, 0x4, 0x8 or 0xC leaves every later read of those addresses unchanged.
- R5: cpu_ack is high in the cycle after each access and low otherwise. cpu_rdata is valid in that same cycle. For a RAM read, cpu_rdata is the ram_rdata value from that cycle.
- R6: A write to 0x0800_0000 while the transmitter is empty places cpu_wdata[7:0] on tx_byte with tx_valid high from the next cycle. Both hold until a cycle with tx_ready high.
- R7: Bit 0 of a read of 0x0800_0004 is 1 when no byte is pending and 0 from the write until the handshake. All other bits read 0.
- R8: A write to 0x0800_0000 while a byte is pending is dropped. tx_byte keeps the earlier byte.
- R9: rx_ready is high exactly when no received byte is waiting. A byte on rx_byte is taken in a cycle with rx_valid and rx_ready both high. After that, bit 0 of a read of 0x0800_000C is 1 and the other bits are 0.
- R10: A read of 0x0800_0008 returns the waiting byte in bits 7:0, with zeros above it. It clears the waiting state, so rx_ready is high again and bit 0 of 0x0800_000C reads 0.
- R11: Unmapped I/O addresses read as zero, and writes to them have no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW | Byte address of the access |
| cpu_wdata | input | DW | Write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | DW | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Access completion, one cycle after the strobe |
| sys_pc | input | DW | Program counter of the active thread |
| sys_psw | input | DW | Status word of the active thread |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_rdata | input | DW | RAM read data, one cycle after ram_rd |
| tx_byte | output | BW | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte is pending |
| tx_ready | input | 1 | Downstream takes the byte |
| rx_byte | input | BW | Incoming byte |
| rx_valid | input | 1 | Incoming byte is offered |
| rx_ready | output | 1 | Block can take an incoming byte |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 32-bit data word, byte-wide buffers, the RAM boundary at 0x2000_0000 and the peripheral at 0x0800_0000. At these values, every word offset of the system bank and of the byte peripheral can be swept, and so can the addresses just below and at the RAM boundary and the edges of the reserved per-processor range. The bench also drives the transmit and receive buffers through their full, dropped-write and blocked-byte corners using handshake timing that it controls. A behavioural RAM in the bench returns a value derived arithmetically from the address, so forwarded reads can be predicted exactly.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic [1:0] {
    RG_SYS    = 2'd0,
    RG_PERIPH = 2'd1,
    RG_RAM    = 2'd2,
    RG_NONE   = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    PX_TXDATA = 2'd0,
    PX_TXSTAT = 2'd1,
    PX_RXDATA = 2'd2,
    PX_RXSTAT = 2'd3
  } periph_reg_e;
endpackage

// File: rtl/region_decode.sv
module region_decode
  import dbus_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RAM_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] PERIPH_BASE = 32'h0800_0000
) (
  input  logic [AW-1:2] word_addr,
  output region_e       region,
  output logic [1:0]    word_idx
);
  localparam logic [AW-1:2] RAM_WORD = RAM_BASE[AW-1:2];
  localparam logic [AW-1:4] PERIPH_BLK = PERIPH_BASE[AW-1:4];

  assign word_idx = word_addr[3:2];

  always_comb begin
    if (word_addr >= RAM_WORD)
      region = RG_RAM;
    else if (word_addr[AW-1:4] == '0)
      region = RG_SYS;
    else if (word_addr[AW-1:4] == PERIPH_BLK)
      region = RG_PERIPH;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int DW = 32
) (
  input  logic [1:0]    idx,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] psw,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] ZERO_WORD = '0;
  localparam logic [DW-1:0] SIGN_WORD = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    unique case (idx)
      2'd0:    rdata = ZERO_WORD;
      2'd1:    rdata = SIGN_WORD;
      2'd2:    rdata = pc;
      default: rdata = psw;
    endcase
  end
endmodule

// File: rtl/byte_port.sv
module byte_port
  import dbus_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_rd,
  input  logic          sel_wr,
  input  logic [1:0]    idx,
  input  logic [BW-1:0] wbyte,
  output logic [DW-1:0] rdata,
  output logic [BW-1:0] tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_valid,
  output logic          rx_ready
);
  localparam int PAD = DW - BW;

  logic          tx_full, rx_full;
  logic [BW-1:0] tx_hold, rx_hold;
  logic          tx_load, rx_take, rx_drain;

  assign tx_load  = sel_wr && (idx == PX_TXDATA) && !tx_full;
  assign rx_take  = rx_valid && !rx_full;
  assign rx_drain = sel_rd && (idx == PX_RXDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (tx_load) begin
      tx_full <= 1'b1;
      tx_hold <= wbyte;
    end else if (tx_full && tx_ready) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
      rx_hold <= '0;
    end else if (rx_take) begin
      rx_full <= 1'b1;
      rx_hold <= rx_byte;
    end else if (rx_drain) begin
      rx_full <= 1'b0;
    end
  end

  assign tx_byte  = tx_hold;
  assign tx_valid = tx_full;
  assign rx_ready = !rx_full;

  always_comb begin
    unique case (idx)
      PX_TXDATA: rdata = {{PAD{1'b0}}, tx_hold};
      PX_TXSTAT: rdata = {{(DW-1){1'b0}}, !tx_full};
      PX_RXDATA: rdata = {{PAD{1'b0}}, rx_hold};
      default:   rdata = {{(DW-1){1'b0}}, rx_full};
    endcase
  end

  // R6: a pending byte is held steady until the handshake
  a_r6_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R8: a write while pending never replaces the held byte
  a_r8_tx_drop: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && sel_wr) |=> $stable(tx_byte));

  // R9: a waiting byte blocks new input until it is read
  a_r9_rx_block: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && !rx_drain) |=> (!rx_ready && $stable(rx_hold)));

  // R10: reading the buffer frees it
  a_r10_rx_clear: assert property (@(posedge clk) disable iff (rst)
    (rx_drain && !rx_ready) |=> rx_ready);
endmodule

// File: rtl/dbus_io_decoder.sv
module dbus_io_decoder
  import dbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 8,
  parameter logic [AW-1:0] RAM_BASE = 32'h2000_0000,
  parameter logic [AW-1:0] PERIPH_BASE = 32'h0800_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ack,
  input  logic [DW-1:0] sys_pc,
  input  logic [DW-1:0] sys_psw,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_rd,
  output logic          ram_wr,
  input  logic [DW-1:0] ram_rdata,
  output logic [BW-1:0] tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_valid,
  output logic          rx_ready
);
  localparam logic [DW-1:0] SIGN_WORD = {1'b1, {(DW-1){1'b0}}};

  region_e       region;
  logic [1:0]    word_idx;
  logic [DW-1:0] sys_rdata, px_rdata, local_rdata;
  logic [DW-1:0] rdata_q;
  logic          ack_q, from_ram_q;

  region_decode #(
    .AW(AW), .RAM_BASE(RAM_BASE), .PERIPH_BASE(PERIPH_BASE)
  ) u_dec (
    .word_addr(cpu_addr[AW-1:2]),
    .region   (region),
    .word_idx (word_idx)
  );

  sysreg_bank #(.DW(DW)) u_sys (
    .idx  (word_idx),
    .pc   (sys_pc),
    .psw  (sys_psw),
    .rdata(sys_rdata)
  );

  byte_port #(.DW(DW), .BW(BW)) u_port (
    .clk     (clk),
    .rst     (rst),
    .sel_rd  (cpu_rd && region == RG_PERIPH),
    .sel_wr  (cpu_wr && region == RG_PERIPH),
    .idx     (word_idx),
    .wbyte   (cpu_wdata[BW-1:0]),
    .rdata   (px_rdata),
    .tx_byte (tx_byte),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .rx_byte (rx_byte),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign ram_rd    = cpu_rd && (region == RG_RAM);
  assign ram_wr    = cpu_wr && (region == RG_RAM);

  always_comb begin
    unique case (region)
      RG_SYS:    local_rdata = sys_rdata;
      RG_PERIPH: local_rdata = px_rdata;
      default:   local_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      ack_q      <= 1'b0;
      from_ram_q <= 1'b0;
    end else begin
      ack_q      <= cpu_rd || cpu_wr;
      from_ram_q <= ram_rd;
      if (cpu_rd)
        rdata_q <= local_rdata;
    end
  end

  assign cpu_ack   = ack_q;
  assign cpu_rdata = from_ram_q ? ram_rdata : rdata_q;

  // R5: one acknowledge per access, one cycle later
  a_r5_ack_follows: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd || cpu_wr) |=> cpu_ack);
  a_r5_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd || cpu_wr) |=> !cpu_ack);

  // R2: sign constant at word 1
  a_r2_sign_const: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == AW'(4)) |=> (cpu_rdata == SIGN_WORD));

  // R11: unmapped I/O reads as zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && region == RG_NONE) |=> (cpu_rdata == '0));
endmodule

// File: tb/dbus_io_decoder_tb.sv
module dbus_io_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_ack;
  logic [31:0] sys_pc = 32'h0000_1234, sys_psw = 32'h0000_0002;
  logic [31:0] ram_addr, ram_wdata;
  logic        ram_rd, ram_wr;
  logic [31:0] ram_rdata = '0;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbus_io_decoder dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .sys_pc(sys_pc), .sys_psw(sys_psw), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_rdata(ram_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  function automatic logic [31:0] ram_model(input logic [31:0] a);
    return (a ^ 32'hA5A5_0000) + 32'd7;
  endfunction

  always_ff @(posedge clk) if (ram_rd) ram_rdata <= ram_model(ram_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one read; checks strobes on the RAM port (R1) and the acknowledge (R5)
  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    chk(ram_rd == (a >= 32'h2000_0000), "R1 ram_rd", {31'd0, ram_rd}, {31'd0, a >= 32'h2000_0000});
    @(negedge clk);
    cpu_rd = 1'b0;
    chk(cpu_ack == 1'b1, "R5 ack", {31'd0, cpu_ack}, 32'd1);
    d = cpu_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    chk(ram_wr == (a >= 32'h2000_0000), "R1 ram_wr", {31'd0, ram_wr}, {31'd0, a >= 32'h2000_0000});
    if (a >= 32'h2000_0000)
      chk(ram_addr == a && ram_wdata == d, "R1 ram fwd", ram_wdata, d);
    @(negedge clk);
    cpu_wr = 1'b0;
    chk(cpu_ack == 1'b1, "R5 wr ack", {31'd0, cpu_ack}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] unm [6];
    logic [31:0] rams [3];
    unm[0] = 32'h0000_0010; unm[1] = 32'h0000_0100; unm[2] = 32'h0400_0000;
    unm[3] = 32'h07FF_FFFC; unm[4] = 32'h0800_0010; unm[5] = 32'h1FFF_FFFC;
    rams[0] = 32'h2000_0000; rams[1] = 32'h3000_0040; rams[2] = 32'hFFFF_FFFC;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_ack && !tx_valid && rx_ready, "R5 reset state", {29'd0, cpu_ack, tx_valid, rx_ready}, 32'd1);

    // R2 R3: system bank under several PC/PSW patterns
    for (int p = 0; p < 4; p++) begin
      sys_pc  = 32'h0000_0200 + 32'(p) * 32'h1111_0004;
      sys_psw = 32'(p);
      for (int i = 0; i < 4; i++) begin
        logic [31:0] e;
        e = (i == 0) ? 32'h0 : (i == 1) ? 32'h8000_0000 : (i == 2) ? sys_pc : sys_psw;
        rd(32'(i * 4), d);
        chk(d == e, (i < 2) ? "R2 const" : "R3 live", d, e);
      end
    end

    // R4: writes to the bank are ignored
    for (int i = 0; i < 4; i++) begin
      logic [31:0] e;
      wr(32'(i * 4), 32'hDEAD_BEEF);
      e = (i == 0) ? 32'h0 : (i == 1) ? 32'h8000_0000 : (i == 2) ? sys_pc : sys_psw;
      rd(32'(i * 4), d);
      chk(d == e, "R4 write ignored", d, e);
    end

    // R11: unmapped I/O read/write
    for (int i = 0; i < 6; i++) begin
      wr(unm[i], 32'hFFFF_FFFF);
      rd(unm[i], d);
      chk(d == 32'h0, "R11 unmapped", d, 32'h0);
    end
    chk(!tx_valid && rx_ready, "R11 no side effect", {30'd0, tx_valid, rx_ready}, 32'd1);

    // R1 R5: RAM forwarding
    for (int i = 0; i < 3; i++) begin
      wr(rams[i], rams[i] + 32'h55);
      rd(rams[i], d);
      chk(d == ram_model(rams[i]), "R5 ram rdata", d, ram_model(rams[i]));
    end

    // R6 R7 R8: transmit path
    rd(32'h0800_0004, d);
    chk(d == 32'h1, "R7 tx idle", d, 32'h1);
    wr(32'h0800_0000, 32'h1234_56A5);
    chk(tx_valid && tx_byte == 8'hA5, "R6 tx byte", {23'd0, tx_valid, tx_byte}, 32'h1A5);
    rd(32'h0800_0004, d);
    chk(d == 32'h0, "R7 tx busy", d, 32'h0);
    wr(32'h0800_0000, 32'h0000_003C);
    chk(tx_valid && tx_byte == 8'hA5, "R8 drop", {23'd0, tx_valid, tx_byte}, 32'h1A5);
    rd(32'h0800_0000, d);
    chk(d == 32'h0000_00A5, "R6 buffer zero-ext", d, 32'hA5);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk(!tx_valid, "R6 handshake", {31'd0, tx_valid}, 32'd0);
    rd(32'h0800_0004, d);
    chk(d == 32'h1, "R7 tx ready again", d, 32'h1);

    // R9 R10: receive path
    rd(32'h0800_000C, d);
    chk(d == 32'h0, "R9 rx empty", d, 32'h0);
    @(negedge clk); rx_byte = 8'h5A; rx_valid = 1'b1;
    @(negedge clk); rx_byte = 8'h77;
    chk(!rx_ready, "R9 rx_ready low", {31'd0, rx_ready}, 32'd0);
    @(negedge clk); rx_valid = 1'b0;
    rd(32'h0800_000C, d);
    chk(d == 32'h1, "R9 rx status", d, 32'h1);
    rd(32'h0800_0008, d);
    chk(d == 32'h0000_005A, "R10 rx data", d, 32'h5A);
    chk(rx_ready, "R10 rx_ready back", {31'd0, rx_ready}, 32'd1);
    rd(32'h0800_000C, d);
    chk(d == 32'h0, "R10 status cleared", d, 32'h0);

    @(negedge clk);
    chk(!cpu_ack, "R5 idle ack", {31'd0, cpu_ack}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule